// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Write-Through

This block sits between a requester and a slower word-addressed memory. Each line holds one word. The low bits of a request address pick a set, and the remaining upper bits form the tag. Both ways of the chosen set are read in the same cycle, and two comparators decide whether either way holds the tag.

A read hit returns the stored word one cycle after the request is accepted. A read miss chooses a way to replace. An empty way is chosen first. When both ways are full, the way that has gone unused longer is chosen, tracked by one bit per set. The block then fetches the word from memory, writes it into the chosen way and returns it.

Writes always go to memory. A write hit also updates the cached copy. A write miss leaves the cache unchanged. Only one request is in flight at a time: `cpu_ready` is low while the block waits on memory.

Top module: `sa2_cache`

## Requirements
- R1: The set index is the request address modulo `NUM_SETS`, which means its low log2(`NUM_SETS`) bits. The tag is the remaining upper address bits. Two addresses with the same index but different tags are different lines, and a request to one set never changes the contents of another set.
- R2: A read that hits raises `cpu_rsp_valid` with `cpu_rsp_hit`=1 and the stored word in the cycle after acceptance, and issues no memory request.
- R3: Both ways of a set are compared in parallel. A line held in either way hits while the other way holds a different valid line.
- R4: A read miss raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the request address in the cycle after acceptance. It holds them until `mem_ack`. In the cycle after `mem_ack` it responds with `cpu_rsp_hit`=0 and the `mem_rdata` value.
- R5: On a read miss, an invalid way of the set is refilled if one exists, way 0 before way 1.
- R6: With both ways valid, the least recently used way is refilled. One bit per set points at the way not touched by the latest hit or refill, and both read hits and write hits count as a use.
- R7: Reset clears every valid bit and every LRU bit. After reset `cpu_ready`=1, `cpu_rsp_valid`=0 and `mem_req`=0, and the first read of any address misses.
- R8: A write raises `mem_req` with `mem_we`=1, the request address and the data in the cycle after acceptance. It responds after `mem_ack` with `cpu_rsp_hit` reporting whether the line was cached. A write hit updates the cached word. A write miss allocates nothing, so a later read of that address misses and returns the written data from memory.
- R9: `cpu_ready` is low from the acceptance of a miss or write until its response. A request presented while `cpu_ready` is low has no effect: no response, no memory request, no state change.
- R10: With two sets of two ways (4 lines), the read sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Request present; accepted when `cpu_ready` is high |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | The request found its line in the cache |
| cpu_rsp_rdata | output | DATA_W | Read data (zero for writes) |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
A read hit responds exactly one cycle after the accepting edge. A miss or write puts its memory request out one cycle after acceptance and responds one cycle after the edge that samples `mem_ack`. The bench memory model acks after a random delay of one to four cycles.

The bench drives each request on a falling edge and counts falling edges until the response appears. It requires a count of exactly one for hits. For misses and writes it checks the memory request the model recorded, then the response that follows the ack. Expected hit flags, data and victim ways come from a reference model of tags, valid bits and LRU bits kept in bench functions.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } cstate_e;

    // Empty way first (way 0 before way 1), otherwise the LRU way.
    function automatic logic pick_victim(input logic [WAYS-1:0] vld, input logic lru);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru;
    endfunction

    function automatic logic [WAYS-1:0] way_onehot(input logic w);
        return w ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/sa2_cache_ways.sv
module sa2_cache_ways import sa2_cache_pkg::*; #(
    parameter int NUM_SETS = 16,
    parameter int IDX_W    = 4,
    parameter int TAG_W    = 12,
    parameter int DATA_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [WAYS-1:0]               wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [WAYS-1:0]               rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [NUM_SETS-1:0] vld;
        logic [TAG_W-1:0]    tags  [NUM_SETS];
        logic [DATA_W-1:0]   words [NUM_SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
            end else if (wr_en[w]) begin
                vld[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en[w]) begin
                tags[wr_idx]  <= wr_tag;
                words[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = vld[rd_idx];
        assign rd_tag[w]   = tags[rd_idx];
        assign rd_data[w]  = words[rd_idx];
    end

endmodule

// File: rtl/sa2_cache_match.sv
module sa2_cache_match import sa2_cache_pkg::*; #(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic [WAYS-1:0]               way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]    way_tag,
    input  logic [WAYS-1:0][DATA_W-1:0]   way_data,
    input  logic [TAG_W-1:0]              req_tag,
    output logic [WAYS-1:0]               hit_vec,
    output logic                          hit,
    output logic                          hit_way,
    output logic [DATA_W-1:0]             hit_data
);

    // One comparator per way, all working in the same cycle.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit      = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign hit_data = hit_way ? way_data[1] : way_data[0];

endmodule

// File: rtl/sa2_cache_repl.sv
module sa2_cache_repl import sa2_cache_pkg::*; #(
    parameter int NUM_SETS = 16,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAYS-1:0]   way_valid,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_way,
    output logic              victim
);

    // lru_bits[s] names the way of set s that was used less recently.
    logic [NUM_SETS-1:0] lru_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_bits <= '0;
        end else if (upd_en) begin
            lru_bits[upd_idx] <= ~upd_way;
        end
    end

    assign victim = pick_victim(way_valid, lru_bits[rd_idx]);

endmodule

// File: rtl/sa2_cache.sv
module sa2_cache import sa2_cache_pkg::*; #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_SETS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_hit,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic             victim;
        logic             hit;
    } pend_t;

    cstate_e state;
    pend_t   pend;

    logic [IDX_W-1:0]              req_idx;
    logic [TAG_W-1:0]              req_tag;
    logic [WAYS-1:0]               way_valid;
    logic [WAYS-1:0][TAG_W-1:0]    way_tag;
    logic [WAYS-1:0][DATA_W-1:0]   way_data;
    logic [WAYS-1:0]               hit_vec;
    logic                          hit;
    logic                          hit_way;
    logic [DATA_W-1:0]             hit_data;
    logic                          victim_way;
    logic                          accept;
    logic                          fill_done;
    logic [WAYS-1:0]               wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic [TAG_W-1:0]              wr_tag;
    logic [DATA_W-1:0]             wr_data;
    logic                          upd_en;
    logic [IDX_W-1:0]              upd_idx;
    logic                          upd_way;

    assign req_idx   = cpu_req_addr[IDX_W-1:0];
    assign req_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
    assign cpu_ready = (state == ST_IDLE);
    assign accept    = cpu_req_valid && cpu_ready;
    assign fill_done = (state == ST_FILL) && mem_ack;

    sa2_cache_ways #(
        .NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_ways (
        .clk(clk), .rst(rst), .rd_idx(req_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .rd_valid(way_valid), .rd_tag(way_tag), .rd_data(way_data)
    );

    sa2_cache_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
        .way_valid(way_valid), .way_tag(way_tag), .way_data(way_data),
        .req_tag(req_tag), .hit_vec(hit_vec), .hit(hit),
        .hit_way(hit_way), .hit_data(hit_data)
    );

    sa2_cache_repl #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_repl (
        .clk(clk), .rst(rst), .rd_idx(req_idx), .way_valid(way_valid),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_way(upd_way),
        .victim(victim_way)
    );

    // Storage write port: a refill of the latched victim, or a write hit.
    always_comb begin
        wr_en   = '0;
        wr_idx  = req_idx;
        wr_tag  = req_tag;
        wr_data = cpu_req_wdata;
        if (fill_done) begin
            wr_en   = way_onehot(pend.victim);
            wr_idx  = pend.idx;
            wr_tag  = pend.tag;
            wr_data = mem_rdata;
        end else if (accept && cpu_req_we && hit) begin
            wr_en = hit_vec;
        end
    end

    // LRU update on every hit (read or write) and every refill.
    always_comb begin
        upd_en  = 1'b0;
        upd_idx = req_idx;
        upd_way = hit_way;
        if (fill_done) begin
            upd_en  = 1'b1;
            upd_idx = pend.idx;
            upd_way = pend.victim;
        end else if (accept && hit) begin
            upd_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            pend          <= '0;
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_hit   <= 1'b0;
            cpu_rsp_rdata <= '0;
            mem_req       <= 1'b0;
            mem_we        <= 1'b0;
            mem_addr      <= '0;
            mem_wdata     <= '0;
        end else begin
            cpu_rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend.idx    <= req_idx;
                        pend.tag    <= req_tag;
                        pend.victim <= victim_way;
                        pend.hit    <= hit;
                        if (cpu_req_we) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_addr  <= cpu_req_addr;
                            mem_wdata <= cpu_req_wdata;
                            state     <= ST_WRITE;
                        end else if (hit) begin
                            cpu_rsp_valid <= 1'b1;
                            cpu_rsp_hit   <= 1'b1;
                            cpu_rsp_rdata <= hit_data;
                        end else begin
                            mem_req  <= 1'b1;
                            mem_we   <= 1'b0;
                            mem_addr <= cpu_req_addr;
                            state    <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        mem_req       <= 1'b0;
                        cpu_rsp_valid <= 1'b1;
                        cpu_rsp_hit   <= 1'b0;
                        cpu_rsp_rdata <= mem_rdata;
                        state         <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        mem_req       <= 1'b0;
                        mem_we        <= 1'b0;
                        cpu_rsp_valid <= 1'b1;
                        cpu_rsp_hit   <= pend.hit;
                        cpu_rsp_rdata <= '0;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sa2_cache_checker.sv
module sa2_cache_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_we,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic [DATA_W-1:0] cpu_req_wdata,
    input logic              cpu_ready,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_hit,
    input logic [DATA_W-1:0] cpu_rsp_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [1:0]        hit_vec,
    input logic [1:0]        way_valid,
    input logic              victim_way
);

    p_read_hit_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_ready && !cpu_req_we && (|hit_vec))
        |=> (cpu_rsp_valid && cpu_rsp_hit && !mem_req));

    p_one_way_hits_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_miss_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_ready && !cpu_req_we && !(|hit_vec))
        |=> (mem_req && !mem_we && mem_addr == $past(cpu_req_addr)));

    p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_fill_resp_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we)
        |=> (cpu_rsp_valid && !cpu_rsp_hit && cpu_rsp_rdata == $past(mem_rdata)));

    p_empty_way_first_r5: assert property (@(posedge clk) disable iff (rst)
        (!way_valid[0]) |-> (victim_way == 1'b0));

    p_write_through_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_ready && cpu_req_we)
        |=> (mem_req && mem_we && mem_wdata == $past(cpu_req_wdata)
             && mem_addr == $past(cpu_req_addr)));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

endmodule

bind sa2_cache sa2_cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_vec(hit_vec), .way_valid(way_valid), .victim_way(victim_way)
);

// File: tb/test_sa2_cache.sv
module test_sa2_cache;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_we = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_ready, cpu_rsp_valid, cpu_rsp_hit;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sa2_cache #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(NS)) i_sa2_cache (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;

    // Memory model and what it saw.
    logic [DW-1:0] mem [256];
    int            mreq_cnt = 0;
    logic [AW-1:0] mlast_addr = '0;
    logic          mlast_we = 1'b0;

    // Reference model of the cache.
    bit            mv [NS][2];
    int            mt [NS][2];
    logic [DW-1:0] md [NS][2];
    bit            ml [NS];
    bit            last_hit;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int s = 0; s < NS; s++) begin
            ml[s] = 1'b0;
            for (int w = 0; w < 2; w++) mv[s][w] = 1'b0;
        end
    endfunction

    function automatic void model_apply(input bit we, input logic [AW-1:0] a,
                                        input logic [DW-1:0] wd, input logic [DW-1:0] fill);
        int s = int'(a) % NS;
        int tg = int'(a) / NS;
        int v;
        for (int w = 0; w < 2; w++) begin
            if (mv[s][w] && mt[s][w] == tg) begin
                if (we) md[s][w] = wd;
                ml[s] = (w == 0);
                return;
            end
        end
        if (we) return;
        v = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
        mv[s][v] = 1'b1;
        mt[s][v] = tg;
        md[s][v] = fill;
        ml[s] = (v == 0);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R7 ready after reset", cpu_ready, 1);
        chk(cpu_rsp_valid == 1'b0, "R7 no response after reset", cpu_rsp_valid, 0);
        chk(mem_req == 1'b0, "R7 no memory request after reset", mem_req, 0);
    endtask

    task automatic run_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int s = int'(a) % NS;
        int tg = int'(a) / NS;
        bit exp_hit = 1'b0;
        logic [DW-1:0] exp_data;
        logic [DW-1:0] fill;
        int start_cnt;
        int cyc;
        exp_data = mem[a];
        for (int w = 0; w < 2; w++)
            if (mv[s][w] && mt[s][w] == tg) begin
                exp_hit = 1'b1;
                exp_data = md[s][w];
            end
        fill = mem[a];
        while (!cpu_ready) @(negedge clk);
        start_cnt = mreq_cnt;
        cpu_req_valid = 1'b1;
        cpu_req_we = we;
        cpu_req_addr = a;
        cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cyc = 1;
        while (!cpu_rsp_valid && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        chk(cpu_rsp_valid == 1'b1, "R4 response arrives", cpu_rsp_valid, 1);
        chk(cpu_rsp_hit == exp_hit, we ? "R8 write hit flag" : "R3 read hit flag",
            cpu_rsp_hit, exp_hit);
        if (!we) chk(cpu_rsp_rdata == exp_data, "R1 read data", cpu_rsp_rdata, exp_data);
        if (!we && exp_hit) begin
            chk(cyc == 1, "R2 hit latency", cyc, 1);
            chk(mreq_cnt == start_cnt, "R2 no memory request on hit", mreq_cnt - start_cnt, 0);
        end else begin
            chk(mreq_cnt == start_cnt + 1 && mlast_addr == a && mlast_we == we,
                we ? "R8 write goes to memory" : "R4 miss fetch address",
                {mlast_we, mlast_addr}, {we, a});
        end
        last_hit = cpu_rsp_hit;
        model_apply(we, a, wd, fill);
    endtask

    // Memory model: acks 1..4 cycles after seeing a request.
    initial begin
        bit busy = 1'b0;
        int lat = 0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 4951) ^ 16'h0A5A;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                busy = 1'b0;
            end else if (mem_req && !busy) begin
                busy = 1'b1;
                lat = int'($urandom % 4);
                mreq_cnt++;
                mlast_addr = mem_addr;
                mlast_we = mem_we;
            end else if (busy) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem[mem_addr];
                    if (mem_we) mem[mem_addr] = mem_wdata;
                end else begin
                    lat--;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit pat [5];
        void'($urandom(32'd20240611));
        do_reset();

        // R10: block sequence 0,8,0,6,8 on 2 sets x 2 ways.
        run_req(0, 8'd0, '0); pat[0] = last_hit;
        run_req(0, 8'd8, '0); pat[1] = last_hit;
        run_req(0, 8'd0, '0); pat[2] = last_hit;
        run_req(0, 8'd6, '0); pat[3] = last_hit;
        run_req(0, 8'd8, '0); pat[4] = last_hit;
        chk({pat[0], pat[1], pat[2], pat[3], pat[4]} == 5'b00100, "R10 hit pattern",
            {pat[0], pat[1], pat[2], pat[3], pat[4]}, 5'b00100);

        // R6: set 0 now holds 8 (way0) and 6 (way1, LRU).
        run_req(0, 8'd6, '0);
        chk(last_hit == 1'b1, "R6 touch 6", last_hit, 1);
        run_req(0, 8'd0, '0);
        chk(last_hit == 1'b0, "R6 0 evicts LRU 8", last_hit, 0);
        run_req(0, 8'd6, '0);
        chk(last_hit == 1'b1, "R6 6 kept", last_hit, 1);
        run_req(0, 8'd8, '0);
        chk(last_hit == 1'b0, "R6 8 was evicted", last_hit, 0);

        // R1/R3/R5: set 1 fills empty ways, both hit, other set untouched.
        run_req(0, 8'd1, '0);
        chk(last_hit == 1'b0, "R5 first fill", last_hit, 0);
        run_req(0, 8'd3, '0);
        chk(last_hit == 1'b0, "R5 second fill into empty way", last_hit, 0);
        run_req(0, 8'd1, '0);
        chk(last_hit == 1'b1, "R3 hit way0", last_hit, 1);
        run_req(0, 8'd3, '0);
        chk(last_hit == 1'b1, "R3 hit way1", last_hit, 1);
        run_req(0, 8'd2, '0);
        run_req(0, 8'd1, '0);
        chk(last_hit == 1'b1, "R1 other set untouched", last_hit, 1);

        // R8: write hit updates copy, write miss does not allocate.
        run_req(1, 8'd3, 16'hBEEF);
        chk(last_hit == 1'b1, "R8 write hit", last_hit, 1);
        run_req(0, 8'd3, '0);
        chk(cpu_rsp_rdata == 16'hBEEF, "R8 updated copy", cpu_rsp_rdata, 16'hBEEF);
        run_req(1, 8'h41, 16'h1234);
        chk(last_hit == 1'b0, "R8 write miss", last_hit, 0);
        run_req(0, 8'h41, '0);
        chk(last_hit == 1'b0 && cpu_rsp_rdata == 16'h1234, "R8 no allocate",
            {last_hit, cpu_rsp_rdata}, {1'b0, 16'h1234});

        // R9: a write presented while busy is ignored.
        begin
            int start_cnt;
            logic [DW-1:0] before72;
            logic [DW-1:0] fill70;
            int extra = 0;
            while (!cpu_ready) @(negedge clk);
            start_cnt = mreq_cnt;
            before72 = mem[8'h72];
            fill70 = mem[8'h70];
            cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = 8'h70;
            @(negedge clk);
            chk(cpu_ready == 1'b0, "R9 busy during miss", cpu_ready, 0);
            cpu_req_we = 1'b1; cpu_req_addr = 8'h72; cpu_req_wdata = 16'hDEAD;
            @(negedge clk);
            cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
            while (!cpu_rsp_valid) @(negedge clk);
            chk(cpu_rsp_rdata == fill70, "R9 miss data", cpu_rsp_rdata, fill70);
            model_apply(0, 8'h70, '0, fill70);
            repeat (4) begin
                @(negedge clk);
                if (cpu_rsp_valid) extra++;
            end
            chk(extra == 0, "R9 no response for ignored request", extra, 0);
            chk(mreq_cnt == start_cnt + 1, "R9 no memory request", mreq_cnt - start_cnt, 1);
            chk(mem[8'h72] == before72, "R9 memory untouched", mem[8'h72], before72);
            run_req(0, 8'h72, '0);
            chk(last_hit == 1'b0, "R9 no allocation", last_hit, 0);
        end

        // R7: reset mid-run drops all lines.
        do_reset();
        run_req(0, 8'd1, '0);
        chk(last_hit == 1'b0, "R7 miss after reset", last_hit, 0);

        // Random mix against the reference model.
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            bit we;
            a  = ($urandom % 4 == 0) ? AW'($urandom % 256) : AW'($urandom % 8);
            we = ($urandom % 4 == 0);
            run_req(we, a, DW'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule